// File: doc/BRIEF.md
# Fuse Bank Read Sequencer

This block turns single fuse-read requests into register traffic toward one of two one-time-programmable read-port controllers. A client hands it an operation code, a bank number and a word index. The block first decides whether the request can be served. If it can, it picks the controller that owns the bank and brings that controller into parallel read mode with a fixed series of read-modify-write register updates. It then reads every word of the bank through the auto-incrementing read port and returns the word the client asked for.

Requests that cannot be served get an answer one cycle after they are accepted and cause no bus traffic. These are other operations, banks in the reserved security range, and indices outside a bank. Delays are counted in clock cycles that are derived from the `CLK_HZ` parameter and rounded up. The minimum times therefore hold at any clock frequency.

Top module: `fuse_bank_reader`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `bus_req` are low.
- R2: Bank 44 is served by the north controller (`bus_sel`=0), which has 3 words. Bank 45 is served by the south controller (`bus_sel`=1), which has 4 words. Each served read ends with one port read (offset 0x4, `bus_we`=0) for every word of the bank.
- R3: A read of a bank above 45, or of a word index at or beyond the bank's word count, answers status 1 (invalid) and makes no bus access.
- R4: A read of banks 0 to 43 with word 0 to 2 answers status 2 (not implemented). The same banks with word 3 or above answer status 1. Neither case makes a bus access.
- R5: Operation codes 1, 2 and 3 (program, sense, override) answer status 3 (unsupported) one cycle after acceptance, with no bus access. Operation code 0 is a read.
- R6: Before the port reads, a served read performs eight register updates in this order. Offset 0x0 is the control register and offset 0x8 is the pointer register. The updates are: clear control bit 15, set control bit 13, set pointer bit 8, set control bit 14, clear control bit 14, set control bit 3, clear control bit 3, set control bit 3. Each update is one read of the register followed by one write to it.
- R7: Each update writes back the value just read, with only the target bit changed.
- R8: After the write that clears control bit 3, the bus stays idle for at least ceil(100 ns × `CLK_HZ`) cycles before the next access.
- R9: Before each port read, the bus stays idle for at least ceil(100 µs × `CLK_HZ`) cycles.
- R10: A served read answers status 0 (ok) with `rsp_data` equal to the port word at the requested index. When the status is not ok, `rsp_data` is zero.
- R11: `busy` is high from the cycle after acceptance through the response cycle. Requests presented while `busy` is high are ignored. Exactly one one-cycle `rsp_valid` pulse answers each accepted request.
- R12: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_sel`, `bus_we`, `bus_addr` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_op | input | 2 | 0 read, 1 program, 2 sense, 3 override |
| req_bank | input | BANK_W | Bank number |
| req_word | input | WORD_W | Word index inside the bank |
| busy | output | 1 | A request is being served |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 invalid, 2 not implemented, 3 unsupported |
| rsp_data | output | 32 | Fuse word, valid when the status is ok |
| bus_req | output | 1 | Register access request |
| bus_sel | output | 1 | Target controller: 0 north, 1 south |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 4 | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The hardest situation to reach from the ports is a new request that arrives while a long read is under way. Reaching it needs a full initialisation pass and thousands of wait cycles to be in progress. The stimulus starts a south-bank read and checks that `busy` is high. It then holds a program request on the inputs for several cycles inside that window. After the read completes, the scoreboard must have seen exactly one response and the bus log must hold exactly the expected number of transfers. The controller model acknowledges transfers with a rotating delay of zero to two cycles, which exercises the handshake-hold rule. Its read pointer only advances when the design has set the auto-increment bit, so a missing or misordered step shows up as wrong data.

// File: rtl/fuse_bank_reader.sv
module fuse_bank_reader #(
  parameter int unsigned CLK_HZ       = 250_000_000,
  parameter int unsigned BANK_W       = 8,
  parameter int unsigned WORD_W       = 8,
  parameter int unsigned SEC_ROWS     = 44,
  parameter int unsigned SEC_WORDS    = 3,
  parameter int unsigned NB_WORDS     = 3,
  parameter int unsigned SB_WORDS     = 4,
  parameter int unsigned PULSE_NS     = 100,
  parameter int unsigned WORD_WAIT_NS = 100_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [WORD_W-1:0] req_word,
  output logic              busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [31:0]       rsp_data,
  output logic              bus_req,
  output logic              bus_sel,
  output logic              bus_we,
  output logic [3:0]        bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata
);

  localparam longint unsigned NS_PER_S  = 64'd1_000_000_000;
  localparam longint unsigned PULSE_RAW = (64'(CLK_HZ) * 64'(PULSE_NS) + NS_PER_S - 1) / NS_PER_S;
  localparam longint unsigned LONG_RAW  = (64'(CLK_HZ) * 64'(WORD_WAIT_NS) + NS_PER_S - 1) / NS_PER_S;
  localparam int unsigned PULSE_CYC = (PULSE_RAW == 0) ? 1 : 32'(PULSE_RAW);
  localparam int unsigned LONG_CYC  = (LONG_RAW == 0) ? 1 : 32'(LONG_RAW);
  localparam int unsigned MAX_CYC   = (LONG_CYC > PULSE_CYC) ? LONG_CYC : PULSE_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [BANK_W-1:0] NB_BANK = BANK_W'(SEC_ROWS);
  localparam logic [BANK_W-1:0] SB_BANK = BANK_W'(SEC_ROWS + 1);
  localparam logic [WORD_W-1:0] SEC_WN  = WORD_W'(SEC_WORDS);
  localparam logic [WORD_W-1:0] NB_WN   = WORD_W'(NB_WORDS);
  localparam logic [WORD_W-1:0] SB_WN   = WORD_W'(SB_WORDS);

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_INVAL = 2'd1;
  localparam logic [1:0] ST_NOIMP = 2'd2;
  localparam logic [1:0] ST_UNSUP = 2'd3;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_PORT = 4'h4;
  localparam logic [3:0] OFF_PTR  = 4'h8;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_PWAIT, S_WWAIT, S_PRD, S_RESP} state_t;

  state_t            state;
  logic [2:0]        step;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] wcnt, word_q, nw_q;
  logic              sel_q;
  logic [31:0]       rmw_q, data_q;
  logic [1:0]        status_q;

  logic [3:0] step_addr;
  logic       step_set;
  logic [4:0] step_bit;

  always_comb begin
    step_addr = OFF_CTRL;
    step_set  = 1'b1;
    step_bit  = 5'd3;
    case (step)
      3'd0: begin step_set = 1'b0; step_bit = 5'd15; end
      3'd1: step_bit = 5'd13;
      3'd2: begin step_addr = OFF_PTR; step_bit = 5'd8; end
      3'd3: step_bit = 5'd14;
      3'd4: begin step_set = 1'b0; step_bit = 5'd14; end
      3'd5: step_bit = 5'd3;
      3'd6: begin step_set = 1'b0; step_bit = 5'd3; end
      default: step_bit = 5'd3;
    endcase
  end

  wire [31:0] bit_mask = 32'd1 << step_bit;

  assign busy       = (state != S_IDLE);
  assign rsp_valid  = (state == S_RESP);
  assign rsp_status = status_q;
  assign rsp_data   = (status_q == ST_OK) ? data_q : 32'd0;

  assign bus_req   = (state == S_RD) || (state == S_WR) || (state == S_PRD);
  assign bus_sel   = sel_q;
  assign bus_we    = (state == S_WR);
  assign bus_addr  = (state == S_PRD) ? OFF_PORT : step_addr;
  assign bus_wdata = (state == S_WR) ? (step_set ? (rmw_q | bit_mask) : (rmw_q & ~bit_mask)) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step     <= 3'd0;
      cnt      <= '0;
      wcnt     <= '0;
      word_q   <= '0;
      nw_q     <= '0;
      sel_q    <= 1'b0;
      rmw_q    <= 32'd0;
      data_q   <= 32'd0;
      status_q <= ST_OK;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          data_q <= 32'd0;
          word_q <= req_word;
          step   <= 3'd0;
          wcnt   <= '0;
          state  <= S_RESP;
          if (req_op != OP_READ)
            status_q <= ST_UNSUP;
          else if (req_bank < NB_BANK)
            status_q <= (req_word < SEC_WN) ? ST_NOIMP : ST_INVAL;
          else if (req_bank == NB_BANK && req_word < NB_WN) begin
            status_q <= ST_OK; sel_q <= 1'b0; nw_q <= NB_WN; state <= S_RD;
          end else if (req_bank == SB_BANK && req_word < SB_WN) begin
            status_q <= ST_OK; sel_q <= 1'b1; nw_q <= SB_WN; state <= S_RD;
          end else
            status_q <= ST_INVAL;
        end
        S_RD: if (bus_ack) begin
          rmw_q <= bus_rdata;
          state <= S_WR;
        end
        S_WR: if (bus_ack) begin
          if (step == 3'd6) begin
            cnt   <= CNT_W'(PULSE_CYC - 1);
            state <= S_PWAIT;
          end else if (step == 3'd7) begin
            cnt   <= CNT_W'(LONG_CYC - 1);
            state <= S_WWAIT;
          end else begin
            step  <= step + 3'd1;
            state <= S_RD;
          end
        end
        S_PWAIT: if (cnt == '0) begin
          step  <= 3'd7;
          state <= S_RD;
        end else cnt <= cnt - 1'b1;
        S_WWAIT: if (cnt == '0) state <= S_PRD;
          else cnt <= cnt - 1'b1;
        S_PRD: if (bus_ack) begin
          if (wcnt == word_q) data_q <= bus_rdata;
          if (wcnt == nw_q - 1'b1) state <= S_RESP;
          else begin
            wcnt  <= wcnt + 1'b1;
            cnt   <= CNT_W'(LONG_CYC - 1);
            state <= S_WWAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [31:0] idle_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= 32'd0;
    else if (bus_req && bus_ack) idle_cnt <= 32'd0;
    else if (!bus_req && idle_cnt != 32'hFFFF_FFFF) idle_cnt <= idle_cnt + 32'd1;
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata) && $stable(bus_sel)); // R12
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && req_op != OP_READ |=> rsp_valid && rsp_status == ST_UNSUP && !bus_req); // R5
  AST_OUT_OF_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && req_op == OP_READ && req_bank > SB_BANK |=> rsp_valid && rsp_status == ST_INVAL && !bus_req); // R3
  AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy ##1 !rsp_valid); // R11
  AST_PORT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && bus_addr == OFF_PORT |-> idle_cnt >= LONG_CYC); // R9

endmodule

// File: tb/sim_fuse_bank_reader.sv
module sim_fuse_bank_reader;
  localparam int unsigned HZ    = 25_000_000;
  localparam int          LONGW = 2500;
  localparam int          SHORTW = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [7:0] req_bank = 0, req_word = 0;
  logic busy, rsp_valid, bus_req, bus_sel, bus_we, bus_ack;
  logic [1:0] rsp_status;
  logic [31:0] rsp_data, bus_wdata, bus_rdata;
  logic [3:0] bus_addr;

  always #4 clk = ~clk;

  fuse_bank_reader #(.CLK_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_word(req_word), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_data(rsp_data), .bus_req(bus_req), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata));

  int n_tests = 0, n_fail = 0;
  typedef struct packed { logic [1:0] st; logic [31:0] d; } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  logic [31:0] m_ctrl[2], m_ptr[2], fuse[2][4];
  int m_rptr[2];
  int log_n = 0, hs_err = 0;
  logic [3:0] l_addr[64];
  logic l_we[64], l_sel[64];
  logic [31:0] l_wd[64];
  int l_gap[64];

  initial begin : slave
    int gap, wc, dly;
    bit first;
    logic [3:0] a0; logic we0, s0; logic [31:0] wd0;
    gap = 100000; first = 1; wc = 0; dly = 0;
    bus_ack = 0; bus_rdata = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin bus_ack = 0; gap = 0; first = 1; end
      if (rst_n) begin
        if (bus_req) begin
          if (first) begin
            first = 0; wc = 0; a0 = bus_addr; we0 = bus_we; wd0 = bus_wdata; s0 = bus_sel;
          end else if (a0 != bus_addr || we0 != bus_we || wd0 != bus_wdata || s0 != bus_sel)
            hs_err++;
          if (wc >= dly % 3) begin
            if (log_n < 64) begin
              l_addr[log_n] = bus_addr; l_we[log_n] = bus_we; l_sel[log_n] = bus_sel;
              l_wd[log_n] = bus_wdata; l_gap[log_n] = gap;
            end
            log_n++;
            if (bus_we) begin
              if (bus_addr == 4'h0) begin
                m_ctrl[bus_sel] = bus_wdata;
                if (bus_wdata[14]) m_rptr[bus_sel] = 0;
              end else if (bus_addr == 4'h8) m_ptr[bus_sel] = bus_wdata;
            end else begin
              if (bus_addr == 4'h0) bus_rdata = m_ctrl[bus_sel];
              else if (bus_addr == 4'h8) bus_rdata = m_ptr[bus_sel];
              else if (bus_addr == 4'h4) begin
                bus_rdata = (m_rptr[bus_sel] < 4) ? fuse[bus_sel][m_rptr[bus_sel]] : 32'd0;
                if (m_ptr[bus_sel][8]) m_rptr[bus_sel]++;
              end else bus_rdata = 32'hDEAD_BEEF;
            end
            bus_ack = 1; dly++;
          end else wc++;
        end else gap++;
      end
    end
  end

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (q.size() == 0) chk(0, "R11 unexpected response", {30'd0, rsp_status}, 32'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_status == e.st, "R3/R4/R5/R10 status", {30'd0, rsp_status}, {30'd0, e.st});
          chk(rsp_data == e.d, "R10 data", rsp_data, e.d);
        end
      end
    end
  end

  task automatic wait_empty();
    int guard;
    guard = 0;
    while (q.size() != 0 && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  task automatic quick(input logic [1:0] op, input logic [7:0] bank, input logic [7:0] word,
                       input logic [1:0] st, input string tag);
    log_n = 0;
    q.push_back('{st: st, d: 32'd0});
    @(negedge clk);
    req_valid = 1; req_op = op; req_bank = bank; req_word = word;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1, {tag, " answer one cycle after acceptance"}, {31'd0, rsp_valid}, 32'd1);
    wait_empty();
    chk(log_n == 0, {tag, " no bus access"}, log_n, 0);
  endtask

  task automatic check_log(input bit sel, input int nw, input logic [31:0] c0, input logic [31:0] p0);
    logic [31:0] c, p, v;
    int e6, e7, e2;
    c = c0; p = p0; e6 = 0; e7 = 0; e2 = 0;
    chk(log_n == 16 + nw, "R2 transfer count", log_n, 16 + nw);
    for (int i = 0; i < 8; i++) begin
      logic [3:0] a; bit s; int b;
      a = 4'h0; s = 1; b = 3;
      case (i)
        0: begin s = 0; b = 15; end
        1: b = 13;
        2: begin a = 4'h8; b = 8; end
        3: b = 14;
        4: begin s = 0; b = 14; end
        5: b = 3;
        6: begin s = 0; b = 3; end
        default: b = 3;
      endcase
      v = (a == 4'h8) ? p : c;
      v = s ? (v | (32'd1 << b)) : (v & ~(32'd1 << b));
      if (l_we[2*i] != 0 || l_addr[2*i] != a || l_we[2*i+1] != 1 || l_addr[2*i+1] != a) e6++;
      if (l_wd[2*i+1] != v) e7++;
      if (a == 4'h8) p = v; else c = v;
    end
    for (int i = 0; i < 16 + nw; i++) if (l_sel[i] != sel) e2++;
    chk(e6 == 0, "R6 step order", e6, 0);
    chk(e7 == 0, "R7 read-modify-write value", e7, 0);
    chk(e2 == 0, "R2 controller select", e2, 0);
    chk(l_gap[14] >= SHORTW, "R8 pulse low time", l_gap[14], SHORTW);
    for (int k = 0; k < nw; k++) begin
      chk(l_addr[16+k] == 4'h4 && l_we[16+k] == 0, "R2 port read", {28'd0, l_addr[16+k]}, 32'h4);
      chk(l_gap[16+k] >= LONGW, "R9 word wait", l_gap[16+k], LONGW);
    end
    chk(hs_err == 0, "R12 request held until ack", hs_err, 0);
  endtask

  task automatic rd(input logic [7:0] bank, input logic [7:0] word, input bit check_busy);
    bit sel; int nw; logic [31:0] c0, p0;
    sel = (bank == 8'd45); nw = sel ? 4 : 3;
    c0 = m_ctrl[sel]; p0 = m_ptr[sel];
    log_n = 0;
    q.push_back('{st: 2'd0, d: fuse[sel][word]});
    @(negedge clk);
    req_valid = 1; req_op = 0; req_bank = bank; req_word = word;
    @(negedge clk);
    req_valid = 0;
    if (check_busy) begin
      chk(busy == 1, "R11 busy after acceptance", {31'd0, busy}, 32'd1);
      req_valid = 1; req_op = 2'd1; req_bank = 8'd44; req_word = 0;
      repeat (3) @(negedge clk);
      req_valid = 0;
    end
    wait_empty();
    chk(busy == 0, "R11 busy low after response", {31'd0, busy}, 32'd0);
    check_log(sel, nw, c0, p0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : driver
    m_ctrl[0] = 32'h5A5A_C3C3; m_ptr[0] = 32'h1234_00F0; m_rptr[0] = 2;
    m_ctrl[1] = 32'h0F0F_A5A5; m_ptr[1] = 32'hFFFF_FEFF; m_rptr[1] = 3;
    fuse[0][0] = 32'h8BAD_F00D; fuse[0][1] = 32'h1357_9BDF; fuse[0][2] = 32'h0000_0015; fuse[0][3] = 32'h0;
    fuse[1][0] = 32'hC0FF_EE11; fuse[1][1] = 32'h2468_ACE0; fuse[1][2] = 32'h7777_1111; fuse[1][3] = 32'h0000_0001;
    repeat (3) @(negedge clk);
    chk(busy == 0 && rsp_valid == 0 && bus_req == 0, "R1 reset outputs",
        {29'd0, busy, rsp_valid, bus_req}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && bus_req == 0, "R1 idle after reset", {30'd0, busy, bus_req}, 32'd0);

    quick(2'd1, 8'd44, 8'd0, 2'd3, "R5 program");
    quick(2'd2, 8'd45, 8'd1, 2'd3, "R5 sense");
    quick(2'd3, 8'd0,  8'd0, 2'd3, "R5 override");
    quick(2'd0, 8'd0,  8'd0, 2'd2, "R4 row 0 word 0");
    quick(2'd0, 8'd43, 8'd2, 2'd2, "R4 row 43 word 2");
    quick(2'd0, 8'd43, 8'd3, 2'd1, "R4 row 43 word 3");
    quick(2'd0, 8'd46, 8'd0, 2'd1, "R3 bank 46");
    quick(2'd0, 8'd255, 8'd0, 2'd1, "R3 bank 255");
    quick(2'd0, 8'd44, 8'd3, 2'd1, "R3 north word 3");
    quick(2'd0, 8'd45, 8'd4, 2'd1, "R3 south word 4");

    rd(8'd44, 8'd0, 0);
    rd(8'd44, 8'd2, 0);
    rd(8'd45, 8'd3, 0);
    rd(8'd45, 8'd1, 1);

    chk(q.size() == 0, "R11 all responses seen", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule